// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the control logic of a parallel NOR flash device. Each strobe on the write input is one command cycle. The block decodes the sequences of these cycles, keeps the device state in a state register, and runs word program and sector erase against an external memory-array port. Parameterised cycle counts stand in for the high-voltage timing. While an operation runs, the block holds a ready output low. Reads during that time return polling status instead of array data.

A sector erase can be suspended, so that other sectors can be read and programmed, and then resumed. Programs and erases aimed at protected sectors are refused unless the temporary unprotect input is high. Every write is ignored while the supply-low input is high. The sector map is non-uniform. The top of the address space is cut into small boot sectors in the top-boot variant, and the bottom is cut into them in the bottom-boot variant.

The array port reads combinationally. The controller writes `old & new` for a program, and it pulses an erase request with a sector index. The array model sets every word of that sector to all ones.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the ready output is high, and a read returns the array word at the read address one cycle after the read strobe.
- R2: The cycles AAh, 55h, A0h and then address+data (command byte in data bits 7:0, address ignored on the prefix cycles) start a program. When it finishes, the word holds the AND of its old value and the data, so no bit goes from 0 to 1.
- R3: The cycles AAh, 55h, 80h, AAh, 55h and then 30h at an address in the target sector start an erase. When it finishes, every word in that sector is all ones and words outside it are unchanged.
- R4: A read while an operation runs returns status: bit 7 is the complement of bit 7 of the program data (0 for an erase), bit 6 is 0 on the first read and flips on every later read, and all other bits are 0. After completion, reads return array data again.
- R5: The ready output goes low on the cycle after the accepting write. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an uninterrupted erase.
- R6: Writing B0h during an erase suspends it, and the ready output is high on the next cycle. While suspended, reads return array data and programs to other sectors run normally. A program to the sector being erased is refused.
- R7: Writing 30h while an erase is suspended resumes it. The erase finishes after only the cycles it had left and then leaves its sector all ones.
- R8: A program or erase whose target sector has its bit set in `sec_prot_i` is refused while `unprot_i` is low: the ready output stays high and the array is unchanged. With `unprot_i` high the same command runs.
- R9: With TOP_BOOT=1, sector index = address bits above LW, except when those bits are all ones: that top block is split into 2^(LW-SW) sectors of 2^SW words with indices 2^(AW-LW)-1 and up. With TOP_BOOT=0 the lowest block is split into indices 0 and up, and large blocks follow them.
- R10: Write strobes are ignored while `vlow_i` is high, and a partly entered sequence is kept intact.
- R11: A wrong byte anywhere in a command prefix (including F0h) returns the block to read mode. A following data write is then not programmed.
- R12: The reset input aborts any operation or suspension without writing the array and returns the block to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Command-cycle write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data / command byte in bits 7:0 |
| rdata_o | output | DW | Read data or polling status |
| rdy_o | output | 1 | High when no program or erase runs |
| vlow_i | input | 1 | Supply at or below lockout level |
| unprot_i | input | 1 | Temporary unprotect |
| sec_prot_i | input | N_SEC | Per-sector protection bits |
| arr_addr_o | output | AW | Array word address |
| arr_rdata_i | input | DW | Array read data (combinational) |
| arr_wdata_o | output | DW | Array write data |
| arr_we_o | output | 1 | Array word write |
| arr_erase_o | output | 1 | Array sector erase request |
| arr_sec_o | output | SEC_W | Sector index for erase |

## Verification
Programs are driven with a pattern that clears bits and then with a pattern that tries to set cleared bits again. Comparing the two shows whether the AND with the old word happens. Polling reads use data whose bit 7 is 0 and data whose bit 7 is 1, and are read back to back, which separates an inverted bit 7 from a missing one and shows whether bit 6 toggles. Protection is tried on the sectors on either side of the large-to-small boundary and between two small sectors, which exposes any error of one in the sector map. Suspend, supply-low and malformed sequences are driven mid-sequence to show that state is kept or dropped as required.

// File: rtl/flash_ctrl_pkg.sv
`timescale 1ns/1ps
package flash_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PARM,
    ST_ERS1, ST_ERS2, ST_ERS3, ST_PBUSY, ST_EBUSY
  } fstate_e;

  localparam logic [7:0] CMD_UNL_A = 8'hAA;
  localparam logic [7:0] CMD_UNL_B = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
endpackage

// File: rtl/flash_sec_map.sv
`timescale 1ns/1ps
module flash_sec_map #(
  parameter int AW       = 23,
  parameter int SW       = 12,
  parameter int LW       = 15,
  parameter int TOP_BOOT = 1,
  parameter int SEC_W    = 9,
  localparam int N_HI    = 1 << (AW - LW),
  localparam int N_SMALL = 1 << (LW - SW),
  localparam int N_SEC   = N_HI - 1 + N_SMALL
) (
  input  logic [AW-SW-1:0] blk_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [AW-LW-1:0] hi;
  logic [LW-SW-1:0] lo;
  assign hi = blk_i[AW-SW-1:LW-SW];
  assign lo = blk_i[LW-SW-1:0];

  generate
    if (TOP_BOOT != 0) begin : g_top
      always_comb begin
        if (&hi) sec_o = SEC_W'(N_HI - 1) + SEC_W'(lo);
        else     sec_o = SEC_W'(hi);
      end
    end else begin : g_bot
      always_comb begin
        if (hi == '0) sec_o = SEC_W'(lo);
        else          sec_o = SEC_W'(hi) + SEC_W'(N_SMALL - 1);
      end
    end
  endgenerate

  // R9
  always_comb begin
    sec_range_chk: assert (int'(sec_o) < N_SEC);
  end
endmodule

// File: rtl/flash_op_timer.sv
`timescale 1ns/1ps
module flash_op_timer #(
  parameter int CYC   = 550,
  localparam int CW   = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(CYC - 1);
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CYC - 1));
  // R5
  load_run_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_i);
endmodule

// File: rtl/flash_poll_status.sv
`timescale 1ns/1ps
module flash_poll_status #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          busy_i,
  input  logic          stat7_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rdata_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (!busy_i) tog_q <= 1'b0;
      else if (rd_i) tog_q <= ~tog_q;
      if (rd_i) begin
        if (busy_i) begin
          rdata_o    <= '0;
          rdata_o[7] <= stat7_i;
          rdata_o[6] <= tog_q;
        end else begin
          rdata_o <= arr_data_i;
        end
      end
    end
  end

  // R4
  poll_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i) |=> (rdata_o[5:0] == '0));
  // R4
  poll_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && $past(rd_i && busy_i)) |=> (rdata_o[6] != $past(rdata_o[6])));
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl import flash_ctrl_pkg::*; #(
  parameter int DW        = 16,
  parameter int AW        = 23,
  parameter int SW        = 12,
  parameter int LW        = 15,
  parameter int TOP_BOOT  = 1,
  parameter int PROG_CYC  = 550,
  parameter int ERASE_CYC = 1000000,
  localparam int N_HI     = 1 << (AW - LW),
  localparam int N_SMALL  = 1 << (LW - SW),
  localparam int N_SEC    = N_HI - 1 + N_SMALL,
  localparam int SEC_W    = $clog2(N_SEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rdy_o,
  input  logic             vlow_i,
  input  logic             unprot_i,
  input  logic [N_SEC-1:0] sec_prot_i,
  output logic [AW-1:0]    arr_addr_o,
  input  logic [DW-1:0]    arr_rdata_i,
  output logic [DW-1:0]    arr_wdata_o,
  output logic             arr_we_o,
  output logic             arr_erase_o,
  output logic [SEC_W-1:0] arr_sec_o
);
  fstate_e          st_q, st_d;
  logic             susp_q, susp_d;
  logic [AW-1:0]    paddr_q;
  logic [DW-1:0]    pdata_q;
  logic [SEC_W-1:0] esec_q, cmd_sec;
  logic             acc, prot_ok, p_load, e_load, p_zero, e_zero, p_busy, e_busy;
  logic [7:0]       cmd;

  assign acc     = wr_i & ~vlow_i;
  assign cmd     = wdata_i[7:0];
  assign p_busy  = (st_q == ST_PBUSY);
  assign e_busy  = (st_q == ST_EBUSY);
  assign prot_ok = unprot_i | ~sec_prot_i[cmd_sec];

  flash_sec_map #(.AW(AW), .SW(SW), .LW(LW), .TOP_BOOT(TOP_BOOT), .SEC_W(SEC_W)) i_map (
    .blk_i (addr_i[AW-1:SW]),
    .sec_o (cmd_sec)
  );

  flash_op_timer #(.CYC(PROG_CYC)) i_ptmr (
    .clk_i, .rst_ni, .load_i(p_load), .run_i(p_busy), .zero_o(p_zero)
  );

  flash_op_timer #(.CYC(ERASE_CYC)) i_etmr (
    .clk_i, .rst_ni, .load_i(e_load), .run_i(e_busy), .zero_o(e_zero)
  );

  always_comb begin
    st_d   = st_q;
    susp_d = susp_q;
    p_load = 1'b0;
    e_load = 1'b0;
    unique case (st_q)
      ST_READ: if (acc) begin
        if (susp_q && cmd == CMD_SECT) begin
          st_d   = ST_EBUSY;
          susp_d = 1'b0;
        end else if (cmd == CMD_UNL_A) st_d = ST_UNL1;
      end
      ST_UNL1: if (acc) st_d = (cmd == CMD_UNL_B) ? ST_UNL2 : ST_READ;
      ST_UNL2: if (acc) begin
        if (cmd == CMD_PROG)                 st_d = ST_PARM;
        else if (cmd == CMD_ERASE && !susp_q) st_d = ST_ERS1;
        else                                  st_d = ST_READ;
      end
      ST_PARM: if (acc) begin
        // refuse protected targets and the sector under a suspended erase
        if (prot_ok && !(susp_q && cmd_sec == esec_q)) begin
          st_d   = ST_PBUSY;
          p_load = 1'b1;
        end else st_d = ST_READ;
      end
      ST_ERS1: if (acc) st_d = (cmd == CMD_UNL_A) ? ST_ERS2 : ST_READ;
      ST_ERS2: if (acc) st_d = (cmd == CMD_UNL_B) ? ST_ERS3 : ST_READ;
      ST_ERS3: if (acc) begin
        if (cmd == CMD_SECT && prot_ok) begin
          st_d   = ST_EBUSY;
          e_load = 1'b1;
        end else st_d = ST_READ;
      end
      ST_PBUSY: if (p_zero) st_d = ST_READ;
      ST_EBUSY: begin
        if (acc && cmd == CMD_SUSP) begin
          st_d   = ST_READ;
          susp_d = 1'b1;
        end else if (e_zero) st_d = ST_READ;
      end
      default: st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_READ;
      susp_q  <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
      esec_q  <= '0;
    end else begin
      st_q   <= st_d;
      susp_q <= susp_d;
      if (p_load) begin
        paddr_q <= addr_i;
        pdata_q <= wdata_i;
      end
      if (e_load) esec_q <= cmd_sec;
    end
  end

  flash_poll_status #(.DW(DW)) i_stat (
    .clk_i, .rst_ni,
    .rd_i       (rd_i),
    .busy_i     (p_busy | e_busy),
    .stat7_i    (p_busy ? ~pdata_q[7] : 1'b0),
    .arr_data_i (arr_rdata_i),
    .rdata_o    (rdata_o)
  );

  assign rdy_o       = ~(p_busy | e_busy);
  assign arr_addr_o  = p_busy ? paddr_q : addr_i;
  assign arr_wdata_o = arr_rdata_i & pdata_q;
  assign arr_we_o    = p_busy & p_zero;
  assign arr_erase_o = e_busy & e_zero & ~(acc && cmd == CMD_SUSP);
  assign arr_sec_o   = esec_q;

  // R2
  we_erase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_we_o && arr_erase_o));
  // R5
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o || arr_erase_o) |=> rdy_o);
  // R6
  susp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_busy && acc && cmd == CMD_SUSP) |=> (rdy_o && !arr_erase_o));
  // R8
  prot_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PARM && acc && !prot_ok) |=> (rdy_o && !arr_we_o));
  // R10
  vlow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && vlow_i && !p_busy && !e_busy) |=> ($stable(st_q) && $stable(susp_q)));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int DW = 16, AW = 8, SW = 2, LW = 5;
  localparam int PC = 20, EC = 40;
  localparam int N_SEC = 15, SEC_W = 4, NW = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0, vlow_i = 1'b0, unprot_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic [DW-1:0]    wdata_i = '0;
  logic [N_SEC-1:0] sec_prot_i = '0;
  logic [DW-1:0]    rdata_o, arr_rdata_i, arr_wdata_o;
  logic [AW-1:0]    arr_addr_o;
  logic             rdy_o, arr_we_o, arr_erase_o;
  logic [SEC_W-1:0] arr_sec_o;

  flash_cmd_ctrl #(.DW(DW), .AW(AW), .SW(SW), .LW(LW), .TOP_BOOT(1),
                   .PROG_CYC(PC), .ERASE_CYC(EC)) i_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o, .rdy_o,
    .vlow_i, .unprot_i, .sec_prot_i, .arr_addr_o, .arr_rdata_i, .arr_wdata_o,
    .arr_we_o, .arr_erase_o, .arr_sec_o);

  // sector index from the map rule (top boot): 0xE0..0xFF split into 4-word sectors 7..14
  function automatic int sec_of(int a);
    return (a >= 224) ? 7 + (a - 224) / 4 : a / 32;
  endfunction
  function automatic logic [15:0] init_val(int i);
    return 16'hC3A5 ^ 16'(i * 16'h0111);
  endfunction

  logic [15:0] mem [NW];
  logic [15:0] em  [NW];
  assign arr_rdata_i = mem[arr_addr_o];

  initial for (int i = 0; i < NW; i++) begin mem[i] = init_val(i); em[i] = init_val(i); end

  always @(posedge clk) begin
    if (arr_we_o) mem[arr_addr_o] <= arr_wdata_o;
    if (arr_erase_o)
      for (int a = 0; a < NW; a++) if (sec_of(a) == int'(arr_sec_o)) mem[a] <= 16'hFFFF;
  end

  int checks = 0, fails = 0;
  typedef struct { logic [15:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q [$];
  logic rd_d = 1'b0;

  task automatic chk(input logic c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd_i;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sb_q.size() == 0) chk(1'b0, "scoreboard underflow", 32'(rdata_o), 0);
      else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(rdata_o == it.exp, it.tag, 32'(rdata_o), 32'(it.exp));
      end
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); wr_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask
  task automatic sb_read(input int a, input logic [15:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); rd_i = 1'b1; addr_i = AW'(a);
    @(negedge clk); rd_i = 1'b0;
  endtask
  task automatic prog_seq(input int a, input logic [15:0] d);
    wr(0, 16'h00AA); wr(0, 16'h0055); wr(0, 16'h00A0); wr(a, d);
  endtask
  task automatic erase_seq(input int a);
    wr(0, 16'h00AA); wr(0, 16'h0055); wr(0, 16'h0080);
    wr(0, 16'h00AA); wr(0, 16'h0055); wr(a, 16'h0030);
  endtask
  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy_o && n < 1000) begin @(negedge clk); n++; end
  endtask
  task automatic em_erase(input int s);
    for (int a = 0; a < NW; a++) if (sec_of(a) == s) em[a] = 16'hFFFF;
  endtask
  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1
    @(negedge clk);
    chk(rdy_o == 1'b1, "R1 ready after reset", 32'(rdy_o), 1);
    sb_read(3, em[3], "R1 read mode data");

    // R2 R4 R5 program with polling, data bit7=0
    prog_seq(8'h10, 16'h0F0F);
    chk(rdy_o == 1'b0, "R5 busy after program accept", 32'(rdy_o), 0);
    sb_read(8'h10, 16'h0080, "R4 program poll first");
    sb_read(8'h10, 16'h00C0, "R4 program poll toggled");
    wait_rdy(n);
    em[8'h10] = em[8'h10] & 16'h0F0F;
    sb_read(8'h10, em[8'h10], "R2 programmed word");

    // R4 bit7=1 data, R5 program length
    prog_seq(8'h11, 16'hA5F0);
    sb_read(8'h11, 16'h0000, "R4 poll inverted bit7");
    wait_rdy(n);
    em[8'h11] = em[8'h11] & 16'hA5F0;
    prog_seq(8'h12, 16'h5A5A);
    wait_rdy(n);
    chk(n == PC, "R5 program busy length", 32'(n), PC);
    em[8'h12] = em[8'h12] & 16'h5A5A;
    sb_read(8'h11, em[8'h11], "R2 second pattern");
    sb_read(8'h12, em[8'h12], "R2 third pattern");

    // R2 no 0->1
    prog_seq(8'h10, 16'hFFF0);
    wait_rdy(n);
    em[8'h10] = em[8'h10] & 16'hFFF0;
    sb_read(8'h10, em[8'h10], "R2 bits only cleared");

    // R3 R4 erase sector 2
    erase_seq(8'h45);
    chk(rdy_o == 1'b0, "R5 busy after erase accept", 32'(rdy_o), 0);
    sb_read(8'h45, 16'h0000, "R4 erase poll first");
    sb_read(8'h45, 16'h0040, "R4 erase poll toggled");
    wait_rdy(n);
    em_erase(2);
    sb_read(8'h40, em[8'h40], "R3 sector start erased");
    sb_read(8'h5F, 16'hFFFF, "R3 sector end erased");
    sb_read(8'h60, em[8'h60], "R3 next sector kept");
    sb_read(8'h3F, em[8'h3F], "R3 previous sector kept");

    // R5 erase length
    erase_seq(8'hA0);
    wait_rdy(n);
    chk(n == EC, "R5 erase busy length", 32'(n), EC);
    em_erase(5);
    sb_read(8'hB7, em[8'hB7], "R3 sector 5 erased");

    // R6 R7 suspend / resume
    erase_seq(8'h20);
    repeat (5) @(negedge clk);
    wr(0, 16'h00B0);
    chk(rdy_o == 1'b1, "R6 ready after suspend", 32'(rdy_o), 1);
    sb_read(8'h05, em[8'h05], "R6 read other sector");
    prog_seq(8'h08, 16'h00FF);
    chk(rdy_o == 1'b0, "R6 program in suspend busy", 32'(rdy_o), 0);
    wait_rdy(n);
    em[8'h08] = em[8'h08] & 16'h00FF;
    sb_read(8'h08, em[8'h08], "R6 program in suspend");
    prog_seq(8'h21, 16'h0000);
    chk(rdy_o == 1'b1, "R6 program to erasing sector refused", 32'(rdy_o), 1);
    sb_read(8'h21, em[8'h21], "R6 erasing sector untouched");
    wr(0, 16'h0030);
    chk(rdy_o == 1'b0, "R7 busy after resume", 32'(rdy_o), 0);
    wait_rdy(n);
    chk(n > 0 && n < EC - 4, "R7 remaining erase time", 32'(n), EC - 6);
    em_erase(1);
    sb_read(8'h21, 16'hFFFF, "R7 resumed erase done");
    sb_read(8'h3F, 16'hFFFF, "R7 resumed erase end");

    // R8 R9 protection and map
    sec_prot_i[9] = 1'b1;
    prog_seq(8'hE9, 16'h0000);
    chk(rdy_o == 1'b1, "R8 protected program refused", 32'(rdy_o), 1);
    sb_read(8'hE9, em[8'hE9], "R8 protected word kept");
    prog_seq(8'hE7, 16'h1234);
    chk(rdy_o == 1'b0, "R9 sector 8 below protected runs", 32'(rdy_o), 0);
    wait_rdy(n);
    em[8'hE7] = em[8'hE7] & 16'h1234;
    prog_seq(8'hEC, 16'h4321);
    chk(rdy_o == 1'b0, "R9 sector 10 above protected runs", 32'(rdy_o), 0);
    wait_rdy(n);
    em[8'hEC] = em[8'hEC] & 16'h4321;
    sb_read(8'hE7, em[8'hE7], "R9 sector 8 word");
    sb_read(8'hEC, em[8'hEC], "R9 sector 10 word");
    unprot_i = 1'b1;
    prog_seq(8'hE9, 16'h00F0);
    chk(rdy_o == 1'b0, "R8 temporary unprotect runs", 32'(rdy_o), 0);
    wait_rdy(n);
    em[8'hE9] = em[8'hE9] & 16'h00F0;
    unprot_i = 1'b0;
    sb_read(8'hE9, em[8'hE9], "R8 unprotected program");
    sec_prot_i[6] = 1'b1;
    erase_seq(8'hC3);
    chk(rdy_o == 1'b1, "R8 protected erase refused", 32'(rdy_o), 1);
    sb_read(8'hC3, em[8'hC3], "R8 protected erase kept");
    prog_seq(8'hDF, 16'h0000);
    chk(rdy_o == 1'b1, "R9 last large sector protected", 32'(rdy_o), 1);
    prog_seq(8'hE0, 16'h0F00);
    chk(rdy_o == 1'b0, "R9 first small sector free", 32'(rdy_o), 0);
    wait_rdy(n);
    em[8'hE0] = em[8'hE0] & 16'h0F00;
    sb_read(8'hE0, em[8'hE0], "R9 first small sector word");
    sb_read(8'hDF, em[8'hDF], "R9 last large word kept");
    sec_prot_i = '0;

    // R10 supply low
    vlow_i = 1'b1;
    prog_seq(8'h70, 16'h0000);
    chk(rdy_o == 1'b1, "R10 writes ignored at low supply", 32'(rdy_o), 1);
    vlow_i = 1'b0;
    sb_read(8'h70, em[8'h70], "R10 word kept");
    wr(0, 16'h00AA); wr(0, 16'h0055); wr(0, 16'h00A0);
    vlow_i = 1'b1;
    wr(8'h71, 16'h0000);
    vlow_i = 1'b0;
    wr(8'h71, 16'h00FF);
    chk(rdy_o == 1'b0, "R10 sequence kept across ignored strobe", 32'(rdy_o), 0);
    wait_rdy(n);
    em[8'h71] = em[8'h71] & 16'h00FF;
    sb_read(8'h71, em[8'h71], "R10 data after ignored strobe");

    // R11 malformed sequences
    wr(0, 16'h00AA); wr(0, 16'h0012); wr(8'h72, 16'h0000);
    chk(rdy_o == 1'b1, "R11 bad second byte", 32'(rdy_o), 1);
    wr(0, 16'h00AA); wr(0, 16'h0055); wr(0, 16'h00F0); wr(8'h72, 16'h0000);
    chk(rdy_o == 1'b1, "R11 reset byte in prefix", 32'(rdy_o), 1);
    sb_read(8'h72, em[8'h72], "R11 word kept");

    // R12 hardware reset
    prog_seq(8'h73, 16'h0000);
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    chk(rdy_o == 1'b1, "R12 ready after reset in program", 32'(rdy_o), 1);
    sb_read(8'h73, em[8'h73], "R12 aborted program kept");
    erase_seq(8'h80);
    repeat (3) @(negedge clk);
    wr(0, 16'h00B0);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    wr(0, 16'h0030);
    chk(rdy_o == 1'b1, "R12 suspension cleared by reset", 32'(rdy_o), 1);
    sb_read(8'h80, em[8'h80], "R12 suspended sector kept");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 0);
    finish_run();
  end
endmodule